// File: doc/BRIEF.md
# Half-Bridge Short-Circuit Detector with Fault Latch

This block watches a set of half-bridge output stages. For every phase it compares the output level that the gate commands call for with the output level actually observed through a digitized comparator flag. When the two disagree, it raises a raw short-circuit flag. Each gate-command edge opens a blanking window, so the normal settling of the output after a switching transition is not reported as a fault. The detector only reports. It has no path back to the gate commands.

A fault latch keeps a record of the short-circuit flag and of an external over-temperature flag as two sticky bits. A disable request is asserted while either bit is held or while either source is present. The shutdown therefore holds without any software action until the controller pulses the clear input. A source that is still active during a clear keeps its bit set.

Top module: `sc_fault_guard`

## Requirements
- R1: A phase whose command is top-only ({top,bot} = 2'b10) expects out_lvl_i high, and a bottom-only command (2'b01) expects it low. If the level is wrong at a clock edge outside blanking, sc_o is high after that edge.
- R2: A phase commanded off (2'b00) or with both legs on (2'b11) is never checked, whatever its level input.
- R3: Any change of either command bit of a phase blanks that phase. The check is skipped at the edge that first samples the change and at the BLANK_CYC edges that follow, and a further change restarts the window. Each phase blanks on its own.
- R4: sc_o is not held. It falls after the first edge at which no phase shows an unblanked mismatch, even while the latch remains set.
- R5: fault_o[0] (short) is set one edge after sc_o is high. fault_o[1] (over-temperature) is set one edge after over_temp_i is sampled high.
- R6: disable_o is high whenever any fault_o bit is set, sc_o is high, or over_temp_i is high.
- R7: A set fault_o bit stays set until fault_clr_i is sampled high, and it is cleared at that edge.
- R8: If a bit's source is active at the edge where fault_clr_i is high, that bit stays set. A bit without an active source is still cleared.
- R9: During and right after reset, sc_o, fault_o and disable_o are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| top_cmd_i | input | NPHASE | Upper-leg gate command per phase |
| bot_cmd_i | input | NPHASE | Lower-leg gate command per phase |
| out_lvl_i | input | NPHASE | Digitized observed output level per phase |
| over_temp_i | input | 1 | Over-temperature flag |
| fault_clr_i | input | 1 | Fault latch clear from the controller |
| sc_o | output | 1 | Raw short-circuit flag |
| fault_o | output | 2 | Latched faults: bit 0 short, bit 1 over-temperature |
| disable_o | output | 1 | Disable request to the output stage |

## Verification
A mismatch sampled at an edge outside blanking appears on sc_o after that same edge. The fault bit it sets follows one edge later. An over-temperature input reaches disable_o at once, through logic only, and reaches fault_o[1] one edge later. The bench drives its inputs on the falling edge and pushes the values its model expects after the next rising edge into a queue. A monitor pops and compares each item 2 ns after that rising edge, so every result is compared in the cycle it is due. The mismatch scenarios are timed so that some end inside the BLANK_CYC window and some outlast it.

// File: rtl/sc_guard_pkg.sv
package sc_guard_pkg;

  // {top,bot} command encoding of one phase
  typedef enum logic [1:0] {
    LEG_OFF  = 2'b00,
    LEG_LOW  = 2'b01,
    LEG_HIGH = 2'b10,
    LEG_BOTH = 2'b11
  } leg_cmd_e;

  localparam int unsigned FLT_SHORT = 0;
  localparam int unsigned FLT_HOT   = 1;
  localparam int unsigned FLT_W     = 2;

  // true when the observed level contradicts a single-leg command
  function automatic logic level_wrong(input leg_cmd_e cmd, input logic lvl);
    case (cmd)
      LEG_HIGH: level_wrong = !lvl;
      LEG_LOW:  level_wrong = lvl;
      default:  level_wrong = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/sc_phase_check.sv
module sc_phase_check
  import sc_guard_pkg::*;
#(
  parameter int unsigned BLANK_CYC = 25
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic top_i,
  input  logic bot_i,
  input  logic lvl_i,
  output logic mis_o
);

  localparam int unsigned CNT_W = (BLANK_CYC < 1) ? 1 : $clog2(BLANK_CYC + 1);
  localparam logic [CNT_W-1:0] BLANK_LD = CNT_W'(BLANK_CYC);

  leg_cmd_e         cmd_now;
  leg_cmd_e         cmd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             cmd_edge;
  logic             quiet;
  logic             mis_q;

  assign cmd_now  = leg_cmd_e'({top_i, bot_i});
  assign cmd_edge = (cmd_now != cmd_q);
  assign quiet    = (cnt_q == '0) && !cmd_edge;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= LEG_OFF;
      cnt_q <= '0;
      mis_q <= 1'b0;
    end else begin
      cmd_q <= cmd_now;
      if (cmd_edge)           cnt_q <= BLANK_LD;
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
      mis_q <= quiet && level_wrong(cmd_now, lvl_i);
    end
  end

  assign mis_o = mis_q;

  // R3: the edge that samples a command change is always blanked
  a_r3_edge_blanks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({top_i, bot_i} != cmd_q) |=> !mis_o);

  // R2: an off or both-on command never yields a flag
  a_r2_no_check_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (top_i == bot_i) |=> !mis_o);

endmodule

// File: rtl/sc_fault_latch.sv
module sc_fault_latch #(
  parameter int unsigned W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] flt_o
);

  logic [W-1:0] flt_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    // set dominates clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        flt_q[i] <= 1'b0;
      else if (set_i[i])  flt_q[i] <= 1'b1;
      else if (clr_i)     flt_q[i] <= 1'b0;
    end

    a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flt_q[i] && !clr_i) |=> flt_q[i]);

    a_r8_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (set_i[i] && clr_i) |=> flt_q[i]);

    a_r7_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i && !set_i[i]) |=> !flt_q[i]);
  end

  assign flt_o = flt_q;

endmodule

// File: rtl/sc_fault_guard.sv
module sc_fault_guard
  import sc_guard_pkg::*;
#(
  parameter int unsigned NPHASE    = 3,
  parameter int unsigned BLANK_CYC = 25
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NPHASE-1:0] top_cmd_i,
  input  logic [NPHASE-1:0] bot_cmd_i,
  input  logic [NPHASE-1:0] out_lvl_i,
  input  logic              over_temp_i,
  input  logic              fault_clr_i,
  output logic              sc_o,
  output logic [FLT_W-1:0]  fault_o,
  output logic              disable_o
);

  logic [NPHASE-1:0] mis;
  logic [FLT_W-1:0]  flt_set;

  for (genvar p = 0; p < NPHASE; p++) begin : g_phase
    sc_phase_check #(
      .BLANK_CYC(BLANK_CYC)
    ) i_check (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .top_i (top_cmd_i[p]),
      .bot_i (bot_cmd_i[p]),
      .lvl_i (out_lvl_i[p]),
      .mis_o (mis[p])
    );
  end

  assign sc_o = |mis;

  always_comb begin
    flt_set            = '0;
    flt_set[FLT_SHORT] = sc_o;
    flt_set[FLT_HOT]   = over_temp_i;
  end

  sc_fault_latch #(
    .W(FLT_W)
  ) i_latch (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (flt_set),
    .clr_i (fault_clr_i),
    .flt_o (fault_o)
  );

  assign disable_o = (|fault_o) || sc_o || over_temp_i;

  a_r5_short_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sc_o |=> fault_o[FLT_SHORT]);

  a_r5_hot_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    over_temp_i |=> fault_o[FLT_HOT]);

  a_r6_disable_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|fault_o) |-> disable_o);

endmodule

// File: tb/test_sc_fault_guard.sv
`timescale 1ns/1ps
module test_sc_fault_guard;

  localparam int NP    = 3;
  localparam int BLANK = 25;

  typedef struct {
    logic       sc;
    logic [1:0] flt;
    logic       dis;
    string      tag;
  } exp_t;

  logic          clk = 0;
  logic          rst_n = 0;
  logic [NP-1:0] top = '0, bot = '0, lvl = '0;
  logic          hot = 0, clr = 0;
  logic          sc, dis;
  logic [1:0]    flt;

  int n_chk = 0, n_bad = 0;
  exp_t q[$];
  string tag = "R9";

  // bench model state
  logic [1:0] m_cmd [NP];
  int         m_cnt [NP];
  logic       m_sc = 0;
  logic [1:0] m_flt = '0;

  always #4 clk = ~clk;

  sc_fault_guard #(.NPHASE(NP), .BLANK_CYC(BLANK)) i_sc_fault_guard (
    .clk_i(clk), .rst_ni(rst_n), .top_cmd_i(top), .bot_cmd_i(bot),
    .out_lvl_i(lvl), .over_temp_i(hot), .fault_clr_i(clr),
    .sc_o(sc), .fault_o(flt), .disable_o(dis));

  task automatic check(string t, logic [3:0] act, logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: {sc,flt,dis} actual %b expected %b at %0t", t, act, exp, $time);
    end
  endtask

  // driver: apply one cycle of stimulus, predict outputs after next rising edge
  task automatic step(logic [NP-1:0] t, logic [NP-1:0] b, logic [NP-1:0] l,
                      logic h, logic c);
    exp_t e;
    logic new_sc;
    logic [1:0] set;
    @(negedge clk);
    top = t; bot = b; lvl = l; hot = h; clr = c;
    new_sc = 0;
    for (int p = 0; p < NP; p++) begin
      logic [1:0] cmd;
      logic edge_s, wrong;
      cmd = {t[p], b[p]};
      edge_s = (cmd != m_cmd[p]);
      wrong = (cmd == 2'b10 && !l[p]) || (cmd == 2'b01 && l[p]);
      if (!edge_s && m_cnt[p] == 0 && wrong) new_sc = 1;
      if (edge_s) m_cnt[p] = BLANK;
      else if (m_cnt[p] > 0) m_cnt[p]--;
      m_cmd[p] = cmd;
    end
    set = {h, m_sc};
    m_flt = set | (c ? 2'b00 : m_flt);
    m_sc = new_sc;
    e.sc = m_sc; e.flt = m_flt; e.dis = (|m_flt) | m_sc | h; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic hold(int n, logic [NP-1:0] t, logic [NP-1:0] b, logic [NP-1:0] l,
                      logic h, logic c);
    for (int i = 0; i < n; i++) step(t, b, l, h, c);
  endtask

  // monitor
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(e.tag, {sc, flt, dis}, {e.sc, e.flt, e.dis});
    end
  end

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int p = 0; p < NP; p++) begin m_cmd[p] = 2'b00; m_cnt[p] = 0; end
    #10;
    check("R9 in reset", {sc, flt, dis}, 4'b0000);
    @(negedge clk); rst_n = 1;
    tag = "R9"; hold(2, 3'b000, 3'b000, 3'b000, 0, 0);

    // R2: off and both-on phases with arbitrary levels
    tag = "R2"; hold(3, 3'b000, 3'b000, 3'b111, 0, 0);
    hold(BLANK + 4, 3'b111, 3'b111, 3'b010, 0, 0);
    hold(3, 3'b111, 3'b111, 3'b101, 0, 0);
    hold(BLANK + 3, 3'b000, 3'b000, 3'b000, 0, 0);

    // R1: phase0 top-only, level matches then goes wrong
    tag = "R1"; hold(BLANK + 4, 3'b001, 3'b000, 3'b001, 0, 0);
    hold(2, 3'b001, 3'b000, 3'b000, 0, 0);
    tag = "R4"; hold(3, 3'b001, 3'b000, 3'b001, 0, 0);
    tag = "R7"; hold(4, 3'b001, 3'b000, 3'b001, 0, 0);
    hold(1, 3'b001, 3'b000, 3'b001, 0, 1);
    hold(2, 3'b001, 3'b000, 3'b001, 0, 0);

    // R1: phase1 bottom-only, level wrongly high
    tag = "R1"; hold(BLANK + 3, 3'b001, 3'b010, 3'b011, 0, 0);
    tag = "R6"; hold(3, 3'b001, 3'b010, 3'b001, 0, 0);
    tag = "R7"; hold(1, 3'b001, 3'b010, 3'b001, 0, 1);

    // R3: mismatch confined to the window after a switch on phase2
    tag = "R3"; hold(BLANK, 3'b101, 3'b010, 3'b001, 0, 0);
    hold(1, 3'b101, 3'b010, 3'b101, 0, 0);
    hold(4, 3'b101, 3'b010, 3'b101, 0, 0);
    // restart: toggle inside window, mismatch stays until just before second expiry
    hold(10, 3'b001, 3'b110, 3'b001, 0, 0);
    hold(BLANK, 3'b101, 3'b010, 3'b001, 0, 0);
    hold(1, 3'b101, 3'b010, 3'b101, 0, 0);
    // phase independence: phase2 switches while phase0 goes wrong
    hold(1, 3'b001, 3'b110, 3'b100, 0, 0);
    hold(3, 3'b001, 3'b110, 3'b100, 0, 0);
    hold(BLANK, 3'b001, 3'b110, 3'b001, 0, 0);
    tag = "R3"; hold(1, 3'b001, 3'b110, 3'b001, 0, 1);
    // mismatch outlasts the window
    hold(BLANK + 4, 3'b101, 3'b010, 3'b001, 0, 0);

    // R5/R8: over-temperature, clear while active
    tag = "R5"; hold(1, 3'b000, 3'b000, 3'b000, 0, 1);
    hold(3, 3'b000, 3'b000, 3'b000, 1, 0);
    tag = "R8"; hold(2, 3'b000, 3'b000, 3'b000, 1, 1);
    hold(1, 3'b000, 3'b000, 3'b000, 0, 0);
    tag = "R6"; hold(2, 3'b000, 3'b000, 3'b000, 0, 0);
    tag = "R8"; hold(1, 3'b000, 3'b000, 3'b000, 0, 1);
    hold(3, 3'b000, 3'b000, 3'b000, 0, 0);

    // R8: short still present during clear
    tag = "R8"; hold(BLANK + 3, 3'b010, 3'b000, 3'b000, 0, 0);
    hold(2, 3'b010, 3'b000, 3'b000, 0, 1);
    hold(1, 3'b010, 3'b000, 3'b010, 0, 1);
    hold(2, 3'b010, 3'b000, 3'b010, 0, 1);
    hold(3, 3'b010, 3'b000, 3'b010, 0, 0);

    @(negedge clk); @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule